// File: doc/BRIEF.md
# Direct-Mapped Cache Tag Store with Match

This block holds the tags of a direct-mapped cache. Each entry stores a tag, a valid bit and a dirty bit. A cache controller presents an index and a tag on a shared bidirectional bus. The block then reports whether the stored entry at that index is valid and holds the same tag. The index, the tag and the stored arrays feed the compare and read paths through combinational logic only, so results follow the inputs with no clock. Writes of tag, valid and dirty take place on the rising clock edge.

The controller picks the operation with two active-low strobes, write and output enable. With both high the block compares. With output enable low it reads back the stored tag onto the bus. With write low it writes. An active-low clear invalidates the whole store: every valid and dirty bit is wiped, and the outputs stay quiet while clear is held. Driving both strobes low is a protocol error. The block refuses that write and raises an error flag.

The index width is a parameter. Fourteen index bits give the full 16K-entry store, and the default is kept small so the block elaborates quickly.

Top module: `tagram_top`

## Requirements
- R1: After synchronous reset every entry is invalid, so a compare at any index gives `match` = 0, `dirty_out` = 0 and `err` = 0.
- R2: At a rising clock edge with `wr_n` = 0, `oe_n` = 1 and `clr_n` = 1 (and no clear guard active), the bus tag, `valid_in` and `dirty_in` are stored at entry `idx`.
- R3: While `wr_n` = 0, `oe_n` = 1 and `clr_n` = 1, `match` is 0 and `dirty_out` equals `dirty_in` (write pass-through).
- R4: With `wr_n` = 1, `oe_n` = 1 and `clr_n` = 1, `match` is 1 exactly when the stored valid bit at `idx` is 1 and the stored tag equals the bus tag. It follows changes of `idx` or of the bus tag without a clock edge.
- R5: A stored entry whose valid bit is 0 never matches, even when its tag equals the bus tag.
- R6: With `oe_n` = 0, `wr_n` = 1 and `clr_n` = 1, the block drives the stored tag of entry `idx` onto `tag_io`, shows the stored dirty bit on `dirty_out`, and holds `match` at 0. Bus and dirty output follow `idx` without a clock edge.
- R7: While `clr_n` = 0, `match` and `dirty_out` are 0 and the block does not drive `tag_io`. Every rising edge seen with `clr_n` = 0 sets all valid and dirty bits to 0.
- R8: A write request is not committed at an edge where `clr_n` = 0, nor at the first edge after such an edge.
- R9: With `oe_n` = 0 and `wr_n` = 0 (and `clr_n` = 1), `err` is 1, `match` is 0, the block does not drive `tag_io`, and nothing is written.
- R10: In compare mode `dirty_out` shows the stored dirty bit of entry `idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and clears act on its rising edge |
| rst | input | 1 | Synchronous active-high reset; invalidates all entries |
| idx | input | IDX_W | Entry index |
| tag_io | inout | TAG_W | Tag bus: tag in for compare and write, stored tag out on read |
| wr_n | input | 1 | Active-low write request |
| oe_n | input | 1 | Active-low tag bus output enable |
| valid_in | input | 1 | Valid bit to write |
| dirty_in | input | 1 | Dirty bit to write |
| clr_n | input | 1 | Active-low flash clear of valid and dirty bits |
| match | output | 1 | High when the valid stored tag equals the bus tag |
| dirty_out | output | 1 | Stored dirty bit, or `dirty_in` during a write |
| err | output | 1 | High while both strobes are low (illegal request) |

## Verification
Two pairs of operations can land on the same edge: a write request together with the clear, and a write request together with output enable. Clear and write meet when the bench holds a write at the edge where the clear is sampled and again at the first edge after clear is released. It then compares that index and expects no match, which shows both the write block and its one-cycle guard. The illegal pair is raised by pulling both strobes low while the bench drives a tag. The bench checks the error flag and a quiet match, then runs a later compare and expects a miss, which shows nothing was written.

// File: rtl/tagram_pkg.sv
package tagram_pkg;

    localparam int TAG_W_DEF = 12;
    localparam int IDX_W_DEF = 8;

    typedef enum logic [2:0] {
        MODE_CLEAR,
        MODE_COMPARE,
        MODE_READ,
        MODE_WRITE,
        MODE_ILLEGAL
    } tr_mode_e;

    // Outputs formed by the output stage for one cycle
    typedef struct packed {
        logic match;
        logic dirty;
        logic drive;
        logic err;
    } tr_out_t;

    // Clear dominates; then the two strobes select the operation
    function automatic tr_mode_e decode_mode(input logic clr_n,
                                             input logic wr_n,
                                             input logic oe_n);
        tr_mode_e m;
        if (!clr_n)
            m = MODE_CLEAR;
        else if (!wr_n && !oe_n)
            m = MODE_ILLEGAL;
        else if (!wr_n)
            m = MODE_WRITE;
        else if (!oe_n)
            m = MODE_READ;
        else
            m = MODE_COMPARE;
        return m;
    endfunction

endpackage

// File: rtl/tagram_ctrl.sv
module tagram_ctrl
    import tagram_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr_n,
    input  logic     wr_n,
    input  logic     oe_n,
    output tr_mode_e mode,
    output logic     flash,
    output logic     wr_commit
);

    // Set for one edge after any edge that saw clear low
    logic guard_q;

    always_ff @(posedge clk) begin
        if (rst)
            guard_q <= 1'b0;
        else
            guard_q <= ~clr_n;
    end

    always_comb begin
        mode      = decode_mode(clr_n, wr_n, oe_n);
        flash     = (mode == MODE_CLEAR);
        wr_commit = (mode == MODE_WRITE) && !guard_q && !rst;
    end

endmodule

// File: rtl/tagram_store.sv
module tagram_store #(
    parameter int IDX_W = 8,
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flash,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] wtag,
    input  logic             wvld,
    input  logic             wdty,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_vld,
    output logic             rd_dty
);

    localparam int DEPTH = 1 << IDX_W;

    logic [TAG_W-1:0] tag_mem [DEPTH];
    logic [DEPTH-1:0] vld_vec;
    logic [DEPTH-1:0] dty_vec;

    // Tag bits need no clear: validity is carried by the status bits
    always_ff @(posedge clk) begin
        if (we)
            tag_mem[idx] <= wtag;
    end

    // Status bits are discrete flops so a clear reaches all of them at once
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic v_q;
        logic d_q;
        always_ff @(posedge clk) begin
            if (rst || flash) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
            end else if (we && (idx == IDX_W'(e))) begin
                v_q <= wvld;
                d_q <= wdty;
            end
        end
        assign vld_vec[e] = v_q;
        assign dty_vec[e] = d_q;
    end

    assign rd_tag = tag_mem[idx];
    assign rd_vld = vld_vec[idx];
    assign rd_dty = dty_vec[idx];

endmodule

// File: rtl/tagram_outmux.sv
module tagram_outmux
    import tagram_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  tr_mode_e         mode,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic             rd_vld,
    input  logic             rd_dty,
    input  logic [TAG_W-1:0] bus_tag,
    input  logic             dirty_in,
    output tr_out_t          outs
);

    always_comb begin
        outs = '0;
        unique case (mode)
            MODE_CLEAR: outs = '0;
            MODE_WRITE: outs.dirty = dirty_in;
            MODE_READ: begin
                outs.drive = 1'b1;
                outs.dirty = rd_dty;
            end
            MODE_COMPARE: begin
                outs.match = rd_vld && (rd_tag == bus_tag);
                outs.dirty = rd_dty;
            end
            MODE_ILLEGAL: begin
                outs.err   = 1'b1;
                outs.dirty = rd_dty;
            end
            default: outs = '0;
        endcase
    end

endmodule

// File: rtl/tagram_top.sv
module tagram_top
    import tagram_pkg::*;
#(
    parameter int IDX_W = IDX_W_DEF,
    parameter int TAG_W = TAG_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    inout  wire  [TAG_W-1:0] tag_io,
    input  logic             wr_n,
    input  logic             oe_n,
    input  logic             valid_in,
    input  logic             dirty_in,
    input  logic             clr_n,
    output logic             match,
    output logic             dirty_out,
    output logic             err
);

    tr_mode_e         mode;
    logic             flash;
    logic             wr_commit;
    logic [TAG_W-1:0] rd_tag;
    logic             rd_vld;
    logic             rd_dty;
    tr_out_t          outs;

    tagram_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .clr_n     (clr_n),
        .wr_n      (wr_n),
        .oe_n      (oe_n),
        .mode      (mode),
        .flash     (flash),
        .wr_commit (wr_commit)
    );

    tagram_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .flash  (flash),
        .we     (wr_commit),
        .idx    (idx),
        .wtag   (tag_io),
        .wvld   (valid_in),
        .wdty   (dirty_in),
        .rd_tag (rd_tag),
        .rd_vld (rd_vld),
        .rd_dty (rd_dty)
    );

    tagram_outmux #(.TAG_W(TAG_W)) u_out (
        .mode     (mode),
        .rd_tag   (rd_tag),
        .rd_vld   (rd_vld),
        .rd_dty   (rd_dty),
        .bus_tag  (tag_io),
        .dirty_in (dirty_in),
        .outs     (outs)
    );

    assign tag_io    = outs.drive ? rd_tag : {TAG_W{1'bz}};
    assign match     = outs.match;
    assign dirty_out = outs.dirty;
    assign err       = outs.err;

endmodule

// File: rtl/tagram_chk.sv
module tagram_chk (
    input logic clk,
    input logic rst,
    input logic clr_n,
    input logic wr_n,
    input logic oe_n,
    input logic dirty_in,
    input logic match,
    input logic dirty_out,
    input logic err
);

    a_r7_clear_quiet: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> (!match && !dirty_out));

    a_r3_write_passthru: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !wr_n && oe_n) |-> (!match && (dirty_out == dirty_in)));

    a_r9_illegal_flag: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !wr_n && !oe_n) |-> (err && !match));

    a_r6_read_no_match: assert property (@(posedge clk) disable iff (rst)
        (clr_n && wr_n && !oe_n) |-> !match);

    a_r4_match_only_compare: assert property (@(posedge clk) disable iff (rst)
        match |-> (clr_n && wr_n && oe_n));

    // R8: the edge that ends a clear sees an empty store and commits nothing
    a_r8_guard_after_clear: assert property (@(posedge clk) disable iff (rst)
        ($past(!clr_n) && clr_n && wr_n && oe_n) |-> !match);

endmodule

bind tagram_top tagram_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr_n     (clr_n),
    .wr_n      (wr_n),
    .oe_n      (oe_n),
    .dirty_in  (dirty_in),
    .match     (match),
    .dirty_out (dirty_out),
    .err       (err)
);

// File: tb/tagram_top_tb.sv
module tagram_top_tb;

    localparam int OP_W = 0;
    localparam int OP_C = 1;
    localparam int OP_R = 2;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  idx;
        logic [11:0] tag;
        logic        v;
        logic        d;
        logic        em;
        logic        ed;
        logic [11:0] et;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 8'd5,   12'hABC, 1'b1, 1'b0, 1'b0, 1'b0, 12'h000},
        '{2'd1, 8'd5,   12'hABC, 1'b0, 1'b0, 1'b1, 1'b0, 12'h000},
        '{2'd1, 8'd5,   12'hABD, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000},
        '{2'd0, 8'd9,   12'h123, 1'b1, 1'b1, 1'b0, 1'b1, 12'h000},
        '{2'd2, 8'd9,   12'h000, 1'b0, 1'b0, 1'b0, 1'b1, 12'h123},
        '{2'd1, 8'd9,   12'h123, 1'b0, 1'b0, 1'b1, 1'b1, 12'h000},
        '{2'd0, 8'd9,   12'h123, 1'b0, 1'b1, 1'b0, 1'b1, 12'h000},
        '{2'd1, 8'd9,   12'h123, 1'b0, 1'b0, 1'b0, 1'b1, 12'h000},
        '{2'd2, 8'd5,   12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 12'hABC},
        '{2'd0, 8'd255, 12'hFFF, 1'b1, 1'b0, 1'b0, 1'b0, 12'h000},
        '{2'd1, 8'd255, 12'hFFF, 1'b0, 1'b0, 1'b1, 1'b0, 12'h000},
        '{2'd1, 8'd0,   12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000},
        '{2'd0, 8'd5,   12'h555, 1'b1, 1'b1, 1'b0, 1'b1, 12'h000},
        '{2'd2, 8'd5,   12'h000, 1'b0, 1'b0, 1'b0, 1'b1, 12'h555},
        '{2'd1, 8'd5,   12'h555, 1'b0, 1'b0, 1'b1, 1'b1, 12'h000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  idx = '0;
    logic        wr_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        valid_in = 1'b0;
    logic        dirty_in = 1'b0;
    logic        clr_n = 1'b1;
    logic        tb_drv = 1'b1;
    logic [11:0] tb_tag = '0;
    wire  [11:0] tag_io;
    logic        match;
    logic        dirty_out;
    logic        err;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    assign tag_io = tb_drv ? tb_tag : 12'bz;

    always #10 clk = ~clk;

    tagram_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .idx       (idx),
        .tag_io    (tag_io),
        .wr_n      (wr_n),
        .oe_n      (oe_n),
        .valid_in  (valid_in),
        .dirty_in  (dirty_in),
        .clr_n     (clr_n),
        .match     (match),
        .dirty_out (dirty_out),
        .err       (err)
    );

    task automatic check(input string req, input string what,
                         input logic [11:0] act, input logic [11:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input int op, input logic [7:0] i, input logic [11:0] t,
                         input logic v, input logic d);
        idx      = i;
        tb_tag   = t;
        valid_in = v;
        dirty_in = d;
        wr_n     = (op == OP_W) ? 1'b0 : 1'b1;
        oe_n     = (op == OP_R) ? 1'b0 : 1'b1;
        tb_drv   = (op != OP_R);
    endtask

    task automatic idle();
        wr_n = 1'b1; oe_n = 1'b1; tb_drv = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: store empty after reset
        drive(OP_C, 8'd0, 12'h000, 1'b0, 1'b0);
        #2;
        check("R1", "match", {11'd0, match}, 12'd0);
        check("R1", "dirty", {11'd0, dirty_out}, 12'd0);
        check("R1", "err", {11'd0, err}, 12'd0);

        // Vector table: R2 R3 R4 R5 R6 R10
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(int'(VEC[k].op), VEC[k].idx, VEC[k].tag, VEC[k].v, VEC[k].d);
            #2;
            check("R2-table", "match", {11'd0, match}, {11'd0, VEC[k].em});
            check("R10", "dirty", {11'd0, dirty_out}, {11'd0, VEC[k].ed});
            if (int'(VEC[k].op) == OP_R)
                check("R6", "bus", tag_io, VEC[k].et);
        end

        // R6: read follows idx without a clock edge
        @(negedge clk);
        drive(OP_R, 8'd9, 12'h000, 1'b0, 1'b0);
        #2;
        check("R6", "bus idx9", tag_io, 12'h123);
        idx = 8'd255;
        #2;
        check("R6", "bus idx255", tag_io, 12'hFFF);
        check("R6", "dirty idx255", {11'd0, dirty_out}, 12'd0);

        // R4: compare follows bus tag without a clock edge
        @(negedge clk);
        drive(OP_C, 8'd5, 12'h555, 1'b0, 1'b0);
        #2;
        check("R4", "match hit", {11'd0, match}, 12'd1);
        tb_tag = 12'h554;
        #2;
        check("R4", "match miss", {11'd0, match}, 12'd0);

        // R9: illegal request
        @(negedge clk);
        drive(OP_W, 8'd3, 12'h3C3, 1'b1, 1'b1);
        oe_n = 1'b0;
        #2;
        check("R9", "err", {11'd0, err}, 12'd1);
        check("R9", "match", {11'd0, match}, 12'd0);
        check("R9", "bus not driven", tag_io, 12'h3C3);
        @(negedge clk);
        idle();
        drive(OP_C, 8'd3, 12'h3C3, 1'b0, 1'b0);
        #2;
        check("R9", "no write", {11'd0, match}, 12'd0);
        check("R9", "err cleared", {11'd0, err}, 12'd0);

        // R7 + R8: clear with a write request held across it
        @(negedge clk);
        clr_n = 1'b0;
        drive(OP_W, 8'd7, 12'h777, 1'b1, 1'b1);
        #2;
        check("R7", "match", {11'd0, match}, 12'd0);
        check("R7", "dirty", {11'd0, dirty_out}, 12'd0);
        check("R7", "bus not driven", tag_io, 12'h777);
        @(negedge clk);
        clr_n = 1'b1;
        @(negedge clk);
        idle();
        drive(OP_C, 8'd7, 12'h777, 1'b0, 1'b0);
        #2;
        check("R8", "write blocked", {11'd0, match}, 12'd0);
        check("R8", "dirty not set", {11'd0, dirty_out}, 12'd0);
        drive(OP_C, 8'd5, 12'h555, 1'b0, 1'b0);
        #2;
        check("R7", "entry invalidated", {11'd0, match}, 12'd0);
        check("R7", "dirty wiped", {11'd0, dirty_out}, 12'd0);
        drive(OP_C, 8'd255, 12'hFFF, 1'b0, 1'b0);
        #2;
        check("R7", "entry255 invalidated", {11'd0, match}, 12'd0);

        // R2: writes resume once the guard has passed
        @(negedge clk);
        drive(OP_W, 8'd7, 12'h777, 1'b1, 1'b1);
        #2;
        check("R3", "write dirty passthru", {11'd0, dirty_out}, 12'd1);
        @(negedge clk);
        drive(OP_C, 8'd7, 12'h777, 1'b0, 1'b0);
        #2;
        check("R2", "write after clear", {11'd0, match}, 12'd1);
        check("R10", "dirty after write", {11'd0, dirty_out}, 12'd1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule